// File: doc/BRIEF.md
# Trap Routing Decision Unit

This block takes a trap request together with the current trap depth, the hypervisor-state word, the processor-state word and the trap type. It returns how the trap is to be handled. From the two state words it works out the privilege level the core is running at, and from that the level the trap will enter. It then applies a fixed priority of routing rules to pick one of five handling paths. The paths are a recovery (reset/error) mode entry, the error state, a guest-watchdog escalation to the hypervisor, a hypervisor vector and a privileged vector.

The result is registered one cycle after the request strobe. It holds the one-hot path, a flag that says whether the trap lands in hypervisor mode, the vector index, the trap level a privileged handler runs at, and the next-next program counter. The vector-table address arithmetic and the actual state-register edits belong to the surrounding trap logic.

Top module: `trap_route_unit`

## Requirements
- R1: The current level is hypervisor when hypervisor-state bit 2 is 1. Otherwise it is privileged when processor-state bit 2 is 1, and user when both are 0. A user or privileged current level enters privileged; a hypervisor current level enters hypervisor.
- R2: When hypervisor-state bit 5 is 1, or the trap level equals MAX_TL-1, the recovery path (route_path bit 0) is taken with vector index 5 and route_to_hyp=1. This rule outranks every other rule.
- R3: Otherwise, a trap level of MAX_TL or above takes the error path (route_path bit 1) with vector index 0, route_to_hyp=0.
- R4: Otherwise, when the trap level exceeds MAX_PTL and the entered level is privileged, the guest-watchdog path (route_path bit 2) is taken with vector index 2 and route_to_hyp=1.
- R5: Otherwise, when the entered level is hypervisor, or it is privileged and the trap type is at least 384, the hypervisor path (route_path bit 3) is taken with vector index equal to the trap type and route_to_hyp=1.
- R6: In every other case the privileged path (route_path bit 4) is taken with vector index equal to the trap type, route_to_hyp=0, and route_level equal to trap level plus 1. On all other paths route_level is 0.
- R7: route_nnpc equals the sampled NPC plus 4.
- R8: All outputs update on the clock edge that samples trap_valid=1. route_valid is high for exactly that one following cycle, and route_path has exactly one bit set. Without a strobe the path, flag, vector, level and nnpc outputs hold their values.
- R9: A synchronous active-low reset clears route_valid, route_path, route_to_hyp, route_vec, route_level and route_nnpc to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_level | input | TL_W (3) | Current trap level |
| hyp_state | input | ST_W (12) | Hypervisor-state word |
| proc_state | input | ST_W (12) | Processor-state word |
| trap_type | input | TT_W (9) | Trap type code |
| trap_npc | input | PC_W (32) | Next program counter at the trap |
| route_valid | output | 1 | Result valid, one cycle per request |
| route_path | output | 5 | One-hot path: bit0 recovery, bit1 error, bit2 watchdog, bit3 hypervisor, bit4 privileged |
| route_to_hyp | output | 1 | Trap lands in hypervisor mode |
| route_vec | output | TT_W (9) | Vector index |
| route_level | output | TL_W (3) | Trap level for the privileged handler |
| route_nnpc | output | PC_W (32) | Next-next program counter |

## Verification
The guest-watchdog path is the hardest case to reach. It needs a trap level strictly between MAX_PTL and MAX_TL-1, hypervisor-state bits 2 and 5 both clear, and nothing else in the priority chain firing first. Random state words with independent bits rarely line up this way. The stimulus therefore draws the trap level uniformly over its whole range and clears the recovery bit three times out of four. Directed cases also pin levels 3 and 4 against each current privilege, and the trap-type boundary 383/384 in both user and privileged mode.

// File: rtl/trap_route_pkg.sv
// Shared types and constants for the trap routing unit.
// Assumes state words are at least 6 bits wide.
package trap_route_pkg;
    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_PRIV  = 2'd1,
        LVL_HYPER = 2'd2
    } priv_lvl_e;

    localparam int NUM_PATHS = 5;
    localparam int PATH_RED  = 0;
    localparam int PATH_ERR  = 1;
    localparam int PATH_WDOG = 2;
    localparam int PATH_HYP  = 3;
    localparam int PATH_PRIV = 4;

    localparam int HYP_PRIV_BIT  = 2;
    localparam int HYP_RED_BIT   = 5;
    localparam int PROC_PRIV_BIT = 2;

    localparam int VEC_RED  = 5;
    localparam int VEC_ERR  = 0;
    localparam int VEC_WDOG = 2;
endpackage

// File: rtl/priv_level_decode.sv
// Derives the running privilege level from the two state words and the
// level a trap will enter. Purely combinational.
module priv_level_decode
    import trap_route_pkg::*;
#(
    parameter int ST_W = 12
) (
    input  logic [ST_W-1:0] hyp_state,
    input  logic [ST_W-1:0] proc_state,
    output priv_lvl_e       cur_lvl,
    output priv_lvl_e       next_lvl
);
    // Hypervisor bit dominates the processor privilege bit.
    always_comb begin
        if (hyp_state[HYP_PRIV_BIT])
            cur_lvl = LVL_HYPER;
        else if (proc_state[PROC_PRIV_BIT])
            cur_lvl = LVL_PRIV;
        else
            cur_lvl = LVL_USER;
    end

    // User and privileged trap into privileged; hypervisor stays put.
    always_comb begin
        next_lvl = (cur_lvl == LVL_HYPER) ? LVL_HYPER : LVL_PRIV;
    end
endmodule

// File: rtl/route_select.sv
// Applies the prioritized routing rules and produces the one-hot path,
// the hypervisor flag, the vector index and the privileged handler level.
// Assumes MAX_PTL < MAX_TL - 1 and that TL_W can hold MAX_TL.
module route_select
    import trap_route_pkg::*;
#(
    parameter int TL_W       = 3,
    parameter int TT_W       = 9,
    parameter int MAX_TL     = 6,
    parameter int MAX_PTL    = 2,
    parameter int HYP_TT_MIN = 384
) (
    input  logic [TL_W-1:0]      trap_level,
    input  logic [TT_W-1:0]      trap_type,
    input  logic                 red_req,
    input  priv_lvl_e            next_lvl,
    output logic [NUM_PATHS-1:0] path,
    output logic                 to_hyp,
    output logic [TT_W-1:0]      vec,
    output logic [TL_W-1:0]      level
);
    localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
    localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYP_TT_MIN);

    logic red_hit, err_hit, wdog_hit, hyp_hit;

    // Raw rule conditions before priority.
    always_comb begin
        red_hit  = red_req || (trap_level == TL_RED);
        err_hit  = (trap_level >= TL_ERR);
        wdog_hit = (trap_level > TL_PMAX) && (next_lvl == LVL_PRIV);
        hyp_hit  = (next_lvl == LVL_HYPER) ||
                   ((next_lvl == LVL_PRIV) && (trap_type >= TT_HMIN));
    end

    // Priority chain selecting exactly one path and its vector data.
    always_comb begin
        path   = '0;
        to_hyp = 1'b0;
        vec    = trap_type;
        level  = '0;
        if (red_hit) begin
            path[PATH_RED] = 1'b1;
            to_hyp         = 1'b1;
            vec            = TT_W'(VEC_RED);
        end else if (err_hit) begin
            path[PATH_ERR] = 1'b1;
            vec            = TT_W'(VEC_ERR);
        end else if (wdog_hit) begin
            path[PATH_WDOG] = 1'b1;
            to_hyp          = 1'b1;
            vec             = TT_W'(VEC_WDOG);
        end else if (hyp_hit) begin
            path[PATH_HYP] = 1'b1;
            to_hyp         = 1'b1;
        end else begin
            path[PATH_PRIV] = 1'b1;
            level           = trap_level + 1'b1;
        end
    end

    // R6: the privileged path never runs above the privileged maximum.
    always_comb begin
        if (path[PATH_PRIV])
            assert_priv_level_R6: assert (trap_level <= TL_PMAX);
    end
endmodule

// File: rtl/trap_route_unit.sv
// Top of the trap routing unit: decodes privilege, routes the trap and
// registers the decision one cycle after the request strobe.
// Assumes a synchronous active-low reset and one request per cycle at most.
module trap_route_unit
    import trap_route_pkg::*;
#(
    parameter int TL_W       = 3,
    parameter int TT_W       = 9,
    parameter int ST_W       = 12,
    parameter int PC_W       = 32,
    parameter int MAX_TL     = 6,
    parameter int MAX_PTL    = 2,
    parameter int HYP_TT_MIN = 384,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [TL_W-1:0] trap_level,
    input  logic [ST_W-1:0] hyp_state,
    input  logic [ST_W-1:0] proc_state,
    input  logic [TT_W-1:0] trap_type,
    input  logic [PC_W-1:0] trap_npc,
    output logic            route_valid,
    output logic [4:0]      route_path,
    output logic            route_to_hyp,
    output logic [TT_W-1:0] route_vec,
    output logic [TL_W-1:0] route_level,
    output logic [PC_W-1:0] route_nnpc
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSN_BYTES);

    priv_lvl_e            cur_lvl, next_lvl;
    logic [NUM_PATHS-1:0] sel_path;
    logic                 sel_hyp;
    logic [TT_W-1:0]      sel_vec;
    logic [TL_W-1:0]      sel_level;

    priv_level_decode #(.ST_W(ST_W)) u_decode (
        .hyp_state (hyp_state),
        .proc_state(proc_state),
        .cur_lvl   (cur_lvl),
        .next_lvl  (next_lvl)
    );

    route_select #(
        .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL),
        .MAX_PTL(MAX_PTL), .HYP_TT_MIN(HYP_TT_MIN)
    ) u_select (
        .trap_level(trap_level),
        .trap_type (trap_type),
        .red_req   (hyp_state[HYP_RED_BIT]),
        .next_lvl  (next_lvl),
        .path      (sel_path),
        .to_hyp    (sel_hyp),
        .vec       (sel_vec),
        .level     (sel_level)
    );

    // Valid pulse follows the request strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) route_valid <= 1'b0;
        else        route_valid <= trap_valid;
    end

    // Decision registers load only on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_path   <= '0;
            route_to_hyp <= 1'b0;
            route_vec    <= '0;
            route_level  <= '0;
            route_nnpc   <= '0;
        end else if (trap_valid) begin
            route_path   <= sel_path;
            route_to_hyp <= sel_hyp;
            route_vec    <= sel_vec;
            route_level  <= sel_level;
            route_nnpc   <= trap_npc + PC_STEP;
        end
    end

    // R8: a request produces a valid result with a single path bit.
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> route_valid && ($countones(route_path) == 1));

    // R8: without a request the decision holds.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> $stable(route_path) && $stable(route_vec) && $stable(route_nnpc));

    // R7: nnpc is the sampled NPC plus one instruction.
    assert_nnpc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> route_nnpc == $past(trap_npc) + PC_STEP);

    // R2: the recovery bit wins over everything.
    assert_red_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && hyp_state[HYP_RED_BIT]) |=>
            route_path[PATH_RED] && route_to_hyp && (route_vec == TT_W'(VEC_RED)));

    // R5: a hypervisor current level never lands in privileged mode.
    assert_hyp_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && hyp_state[HYP_PRIV_BIT]) |=> !route_path[PATH_PRIV]);
endmodule

// File: tb/trap_route_unit_tb_top.sv
// Self-checking bench: directed corners plus seeded random traps,
// compared against a reference function written from the requirements.
module trap_route_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_valid;
    logic [2:0]  trap_level;
    logic [11:0] hyp_state, proc_state;
    logic [8:0]  trap_type;
    logic [31:0] trap_npc;
    logic        route_valid;
    logic [4:0]  route_path;
    logic        route_to_hyp;
    logic [8:0]  route_vec;
    logic [2:0]  route_level;
    logic [31:0] route_nnpc;

    int checks = 0;
    int fails  = 0;
    int seed   = 1234;

    always #2 clk = ~clk;

    trap_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid),
        .trap_level(trap_level), .hyp_state(hyp_state), .proc_state(proc_state),
        .trap_type(trap_type), .trap_npc(trap_npc), .route_valid(route_valid),
        .route_path(route_path), .route_to_hyp(route_to_hyp), .route_vec(route_vec),
        .route_level(route_level), .route_nnpc(route_nnpc)
    );

    // Reference: {path[4:0], to_hyp, vec[8:0], level[2:0]}
    function automatic logic [17:0] ref_route(input logic [2:0] tl, input logic [11:0] hs,
                                              input logic [11:0] ps, input logic [8:0] tt);
        logic nxt_hyp;
        nxt_hyp = hs[2];
        if (hs[5] || tl == 3'd5)            return {5'b00001, 1'b1, 9'd5, 3'd0};
        if (tl >= 3'd6)                     return {5'b00010, 1'b0, 9'd0, 3'd0};
        if (tl > 3'd2 && !nxt_hyp)          return {5'b00100, 1'b1, 9'd2, 3'd0};
        if (nxt_hyp || tt >= 9'd384)        return {5'b01000, 1'b1, tt, 3'd0};
        if (ps[2] == ps[2])                 return {5'b10000, 1'b0, tt, tl + 3'd1};
        return '0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one request and check the registered result.
    task automatic run_trap(input string req, input logic [2:0] tl, input logic [11:0] hs,
                            input logic [11:0] ps, input logic [8:0] tt, input logic [31:0] npc);
        logic [17:0] e;
        @(negedge clk);
        trap_valid = 1'b1; trap_level = tl; hyp_state = hs;
        proc_state = ps; trap_type = tt; trap_npc = npc;
        e = ref_route(tl, hs, ps, tt);
        @(negedge clk);
        trap_valid = 1'b0;
        check({req, " route"}, {46'd0, route_path, route_to_hyp, route_vec, route_level}, {46'd0, e});
        check("R7 nnpc", {32'd0, route_nnpc}, {32'd0, npc + 32'd4});
        check("R8 valid", {63'd0, route_valid}, 64'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [4:0] held;
        rst_n = 1'b0; trap_valid = 1'b0; trap_level = '0; hyp_state = '0;
        proc_state = '0; trap_type = '0; trap_npc = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {63'd0, route_valid}, 64'd0);
        check("R9 reset outs", {route_path, route_to_hyp, route_vec, route_level, route_nnpc},
              64'd0);
        rst_n = 1'b1;

        // R1: level derivation seen through routing
        run_trap("R1 user", 3'd0, 12'h000, 12'h000, 9'd10, 32'h100);
        run_trap("R1 priv", 3'd1, 12'h000, 12'h004, 9'd20, 32'h200);
        run_trap("R1 hyper", 3'd1, 12'h004, 12'h000, 9'd30, 32'h300);
        // R2: recovery priority
        run_trap("R2 redbit", 3'd0, 12'h024, 12'h004, 9'd400, 32'h400);
        run_trap("R2 tl5", 3'd5, 12'h000, 12'h000, 9'd7, 32'h500);
        // R3: error state
        run_trap("R3 tl6", 3'd6, 12'h004, 12'h000, 9'd7, 32'h600);
        run_trap("R3 tl7", 3'd7, 12'h000, 12'h004, 9'd7, 32'h700);
        // R4: watchdog
        run_trap("R4 wdog user", 3'd3, 12'h000, 12'h000, 9'd50, 32'h800);
        run_trap("R4 wdog priv", 3'd4, 12'h000, 12'h004, 9'd450, 32'h900);
        run_trap("R4 hyper not wdog", 3'd4, 12'h004, 12'h000, 9'd60, 32'hA00);
        // R5/R6: type threshold
        run_trap("R5 tt384", 3'd2, 12'h000, 12'h004, 9'd384, 32'hB00);
        run_trap("R6 tt383", 3'd2, 12'h000, 12'h004, 9'd383, 32'hC00);
        run_trap("R5 user tt384", 3'd0, 12'h000, 12'h000, 9'd384, 32'hD00);
        run_trap("R6 user tt383", 3'd2, 12'h000, 12'h000, 9'd383, 32'hFFFF_FFFC);

        // R8: hold without a request
        held = route_path;
        @(negedge clk);
        trap_level = 3'd6; hyp_state = 12'h020;
        @(negedge clk);
        check("R8 valid low", {63'd0, route_valid}, 64'd0);
        check("R8 path hold", {59'd0, route_path}, {59'd0, held});

        // Random traps
        for (int i = 0; i < 2000; i++) begin
            logic [11:0] hs;
            hs = 12'($urandom(seed));
            seed = seed + 1;
            if ((i % 4) != 0) hs[5] = 1'b0;
            run_trap("R1-6 random", 3'($urandom()), hs, 12'($urandom()),
                     9'($urandom()), $urandom());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule